// File: doc/BRIEF.md
# Dual-Channel Timer Compare Unit

This block watches the count of a timer shared with other logic and compares it against two independent compare registers. Each channel has an equality comparator that runs all the time. It drives a match strobe to a downstream waveform generator, and it keeps a compare-match flag that software can turn into an interrupt. The unit also passes the counter's top and bottom conditions to that waveform generator, so the generator receives everything it needs in one place.

Software writes the compare registers, the interrupt-enable bits and the flag-clear bits over a simple write port. The flag is captured only on a timer tick. This means the flag rises one tick after the count reaches the compare value, and a stopped timer raises no new flags. A flag clears in one of two ways: an interrupt-acknowledge pulse from the interrupt controller, or a write of a one to the flag-clear location.

Top module: `ocmp_dual`

## Requirements
- R1: After reset, both compare registers hold 0, both flags are 0, both interrupt enables are 0, and both `irq` outputs are 0.
- R2: `cmp_match[i]` is high in the same cycle, with no register delay, exactly when `count` equals channel i's compare register. Channel i's compare register is at write address i (0 or 1).
- R3: A compare-register write is used by the comparator from the clock cycle after the write edge. The value before the write applies up to that edge.
- R4: `flag[i]` becomes 1 on a clock edge at which both `tick` and `cmp_match[i]` are high. While `tick` is low, no flag is set, even when the count matches.
- R5: `irq[i]` is high exactly when `flag[i]` is 1 and enable bit i is 1. The enable bits are written at address 3, with bit i of `wr_data` enabling channel i.
- R6: A high `irq_ack[i]` at a clock edge clears `flag[i]`.
- R7: A write to address 2 clears `flag[i]` for each bit i of `wr_data` that is 1. Bits that are 0 leave their flag unchanged.
- R8: If a set condition (R4) and a clear condition (R6 or R7) occur on the same edge, the flag ends up set.
- R9: The two channels are independent. A match, a set or a clear on one channel never changes the other channel's match, flag or request.
- R10: `cnt_bottom` is high exactly when `count` is 0, and `cnt_top` is high exactly when `count` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick enable for this cycle |
| count | input | CNT_W | Shared timer count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0..NUM_CH-1 compare, NUM_CH flag clear, NUM_CH+1 enables |
| wr_data | input | CNT_W | Write data |
| irq_ack | input | NUM_CH | Interrupt acknowledge per channel |
| cmp_match | output | NUM_CH | Equality strobe per channel to the waveform generator |
| cnt_top | output | 1 | Count is at its maximum value |
| cnt_bottom | output | 1 | Count is zero |
| flag | output | NUM_CH | Compare-match flags |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
The hardest situations to reach are the collisions on a single clock edge: a timer tick with a matching count that lands on the same edge as an acknowledge or a flag-clear write. The bench produces these deliberately. It parks the count on the compare value and raises the tick, the clear source and the write strobe together for exactly one edge. It also steps the tick off with the count still matching, which shows that a stopped timer sets nothing. Comparator behaviour is swept over every compare value against every count, with the two channels loaded with mirrored values so that their matches never coincide by accident.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    // Per-channel flag events gathered for one clock edge
    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    // Register slots that follow the compare registers: flag clear, enables
    localparam int EXTRA_SLOTS = 2;

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CNT_W-1:0]                 wr_data,
    output logic [NUM_CH-1:0][CNT_W-1:0]     cmp_val,
    output logic [NUM_CH-1:0]                irq_en,
    output logic [NUM_CH-1:0]                clr_wr
);

    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] ENA_ADDR = ADDR_W'(NUM_CH + 1);

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0] cmp;
        logic [NUM_CH-1:0]            ena;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        clr_wr = '0;
        if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    r_d.cmp[i] = wr_data;
                end
            end
            if (wr_addr == CLR_ADDR) begin
                clr_wr = wr_data[NUM_CH-1:0];
            end
            if (wr_addr == ENA_ADDR) begin
                r_d.ena = wr_data[NUM_CH-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmp_val = r_q.cmp;
    assign irq_en  = r_q.ena;

endmodule

// File: rtl/ocmp_chan.sv
module ocmp_chan
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             irq_en,
    input  logic             ack,
    input  logic             w1c,
    output logic             match,
    output logic             flag,
    output logic             irq
);

    typedef struct packed {
        logic flag;
    } chan_t;

    chan_t     s_d, s_q;
    flag_evt_t evt;

    always_comb begin
        match   = (count == cmp_val);
        evt.set = tick & match;
        evt.clr = ack | w1c;
        s_d     = s_q;
        if (evt.set) begin
            s_d.flag = 1'b1;
        end else if (evt.clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag = s_q.flag;
    assign irq  = s_q.flag & irq_en;

endmodule

// File: rtl/ocmp_edges.sv
module ocmp_edges #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    output logic             at_top,
    output logic             at_bottom
);

    always_comb begin
        at_top    = (count == '1);
        at_bottom = (count == '0);
    end

endmodule

// File: rtl/ocmp_dual.sv
module ocmp_dual #(
    parameter int   CNT_W  = 8,
    parameter int   NUM_CH = 2,
    localparam int  ADDR_W = $clog2(NUM_CH + ocmp_pkg::EXTRA_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] irq_ack,
    output logic [NUM_CH-1:0] cmp_match,
    output logic              cnt_top,
    output logic              cnt_bottom,
    output logic [NUM_CH-1:0] flag,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0][CNT_W-1:0] cmp_val;
    logic [NUM_CH-1:0]            irq_en;
    logic [NUM_CH-1:0]            clr_wr;

    ocmp_regs #(
        .CNT_W (CNT_W),
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cmp_val(cmp_val),
        .irq_en (irq_en),
        .clr_wr (clr_wr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ocmp_chan #(
            .CNT_W(CNT_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .count  (count),
            .cmp_val(cmp_val[g]),
            .irq_en (irq_en[g]),
            .ack    (irq_ack[g]),
            .w1c    (clr_wr[g]),
            .match  (cmp_match[g]),
            .flag   (flag[g]),
            .irq    (irq[g])
        );
    end

    ocmp_edges #(
        .CNT_W(CNT_W)
    ) u_edges (
        .count    (count),
        .at_top   (cnt_top),
        .at_bottom(cnt_bottom)
    );

endmodule

// File: rtl/ocmp_dual_chk.sv
module ocmp_dual_chk #(
    parameter int  CNT_W  = 8,
    parameter int  NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH + ocmp_pkg::EXTRA_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [CNT_W-1:0]  count,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [NUM_CH-1:0] irq_ack,
    input logic [NUM_CH-1:0] cmp_match,
    input logic              cnt_top,
    input logic              cnt_bottom,
    input logic [NUM_CH-1:0] flag,
    input logic [NUM_CH-1:0] irq
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R3
        new_cmp_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(g)) |=> (cmp_match[g] == (count == $past(wr_data))));

        // R4
        flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[g]) |-> $past(tick && cmp_match[g]));

        // R5
        irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> flag[g]);

        // R6
        ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[g] && !(tick && cmp_match[g])) |=> !flag[g]);

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && cmp_match[g]) |=> flag[g]);
    end

    // R10
    bottom_not_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (cnt_bottom && !cnt_top));

endmodule

bind ocmp_dual ocmp_dual_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/ocmp_dual_tb.sv
module ocmp_dual_tb;

    localparam int CNT_W  = 8;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [CNT_W-1:0]  count = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [NUM_CH-1:0] irq_ack = '0;
    logic [NUM_CH-1:0] cmp_match;
    logic              cnt_top;
    logic              cnt_bottom;
    logic [NUM_CH-1:0] flag;
    logic [NUM_CH-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ocmp_dual #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_ack(irq_ack), .cmp_match(cmp_match), .cnt_top(cnt_top),
        .cnt_bottom(cnt_bottom), .flag(flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write cycle: driven after a falling edge, taken at the next rising edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One clock edge with the given tick and acknowledge values
    task automatic step(input logic t, input logic [NUM_CH-1:0] ak);
        @(negedge clk);
        tick = t; irq_ack = ak;
        @(negedge clk);
        tick = 1'b0; irq_ack = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
        count = 8'd0; #1;
        chk("R1 cmp zero match", cmp_match, 3);
        count = 8'd5; #1;
        chk("R1 cmp zero nomatch", cmp_match, 0);

        // R2 R9 R10: every compare value against every count, mirrored channels
        for (int c = 0; c < 256; c++) begin
            wr(2'd0, 8'(c));
            wr(2'd1, 8'(255 - c));
            for (int n = 0; n < 256; n++) begin
                count = 8'(n); #1;
                chk("R2 ch0", cmp_match[0], int'(n == c));
                chk("R9 ch1", cmp_match[1], int'(n == 255 - c));
                chk("R10 bottom", cnt_bottom, int'(n == 0));
                chk("R10 top", cnt_top, int'(n == 255));
            end
        end
        chk("R4 no flag from sweep", flag, 0);

        // R3: cmp0=255 now; new value visible only after the write edge
        @(negedge clk);
        count = 8'd7; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd7; #1;
        chk("R3 before edge", cmp_match[0], 0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 after edge", cmp_match[0], 1);

        // R4: matching count without tick sets nothing (cmp1 = 0)
        step(1'b0, 2'b00);
        step(1'b0, 2'b00);
        chk("R4 no tick", flag, 0);
        step(1'b1, 2'b00);
        chk("R4 tick sets ch0", flag, 1);

        // R5: enables gate the request
        chk("R5 disabled", irq, 0);
        wr(2'd3, 8'h01);
        chk("R5 enabled ch0", irq, 1);

        // R7: write-one-to-clear
        wr(2'd2, 8'h00);
        chk("R7 zero no effect", flag, 1);
        wr(2'd2, 8'h02);
        chk("R7 other bit", flag, 1);
        wr(2'd2, 8'h01);
        chk("R7 cleared", flag, 0);
        chk("R7 irq dropped", irq, 0);

        // R6: acknowledge clears
        step(1'b1, 2'b00);
        chk("R6 set again", flag, 1);
        step(1'b0, 2'b01);
        chk("R6 ack clears", flag, 0);

        // R8: set beats acknowledge on the same edge
        step(1'b1, 2'b01);
        chk("R8 set vs ack", flag, 1);
        // R8: set beats write-one-to-clear on the same edge
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R8 set vs w1c", flag, 1);

        // R9: channel 1 sets while channel 0 is cleared and held
        wr(2'd2, 8'h03);
        count = 8'd0;
        wr(2'd3, 8'h03);
        step(1'b1, 2'b00);
        chk("R9 ch1 only flag", flag, 2);
        chk("R9 ch1 only irq", irq, 2);
        step(1'b0, 2'b10);
        chk("R9 ack ch1", flag, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule